// File: doc/BRIEF.md
# PCM Sample Buffer with Interrupt Flags

This block sits between a producer of signed PCM samples (a CPU or a DMA channel) and a PWM conversion stage. Samples are written through a simple write port, each write tagged as coming from the DMA side or the CPU side. The conversion stage pops one sample per PWM period and reads the value the cycle after the pop. When it pops from an empty buffer, the previous sample is presented again so the converter keeps a valid value.

Four conditions are detected and latched into a status register: DMA burst too long, underrun, overflow and data request. The status bits are set whatever the enables hold. A separate enable register decides which latched bits drive the single combined interrupt line. Status bits are cleared by writing ones to a clear port. A programmable block-size field sets two things: the free-space level at which a data request is raised, and the number of DMA writes allowed per request.

Top module: `pcm_sample_fifo`

## Requirements
- R1: After reset, irq_status, irq_enable, irq_line and rd_sample are all zero.
- R2: Samples accepted by the buffer come out in write order, and rd_sample shows the popped sample from the cycle after the pop.
- R3: A write while the buffer holds DEPTH samples sets irq_status bit 2 (overflow), and the sample is discarded and never read out.
- R4: A pop while the buffer is empty sets irq_status bit 1 (underrun), and rd_sample keeps the previously delivered sample.
- R5: irq_status bit 3 (data request) sets on a successful pop with no write accepted in that cycle, when the pop leaves exactly blk_size + 1 free entries.
- R6: irq_status bit 0 (DMA block error) sets on a DMA write (wr_from_dma = 1) that arrives when blk_size + 1 DMA writes have already been counted since the last data request. A data request event sets that count back to zero.
- R7: Status bits latch whatever the enable bits hold, and a status bit stays set until it is cleared.
- R8: irq_line is high exactly when some bit is set in both irq_status and irq_enable. irq_enable takes irq_en_wdata on a cycle with irq_en_we.
- R9: A clear write sets to zero every status bit whose irq_clr_wdata bit is 1. Bits written as 0 are unchanged.
- R10: If a clear of a bit and a new event on that bit happen in the same cycle, the bit stays set.
- R11: CPU writes (wr_from_dma = 0) do not count toward the DMA burst limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write a sample this cycle |
| wr_from_dma | input | 1 | The write comes from the DMA side |
| wr_data | input | SW | Signed sample to store |
| rd_pop | input | 1 | Conversion side takes one sample |
| rd_sample | output | SW | Sample delivered by the last pop |
| blk_size | input | $clog2(DEPTH) | Block size minus one (request threshold and DMA burst limit) |
| irq_en_we | input | 1 | Write the enable register |
| irq_en_wdata | input | 4 | New enable value |
| irq_clr_we | input | 1 | Write the clear register |
| irq_clr_wdata | input | 4 | Ones select the status bits to clear |
| irq_enable | output | 4 | Current enable register |
| irq_status | output | 4 | Latched status: bit0 DMA block error, bit1 underrun, bit2 overflow, bit3 data request |
| irq_line | output | 1 | Combined interrupt |

## Verification
The assertions assume that blk_size never exceeds DEPTH - 1 and only changes while no burst is in progress. They also assume that wr_from_dma has meaning only together with wr_valid. The stimulus holds blk_size at a single legal value for the whole run, and it drives every input only after reset is released and only away from the clock edge. Writes and pops are never issued in the same cycle, except where a requirement names that case. This keeps the request condition unambiguous against the bench model.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;

  localparam int NIRQ       = 4;
  localparam int IRQ_BLKERR = 0;
  localparam int IRQ_UNDER  = 1;
  localparam int IRQ_OVER   = 2;
  localparam int IRQ_REQ    = 3;

  // advance a ring pointer over a buffer of any depth
  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // a pop from a buffer holding fill_before entries leaves blk+1 free slots
  function automatic logic req_hit(int unsigned fill_before, int unsigned depth,
                                   int unsigned blk);
    return (depth - (fill_before - 1)) == (blk + 1);
  endfunction

  // the burst already holds every write one block allows
  function automatic logic burst_full(int unsigned cnt, int unsigned blk);
    return cnt >= blk + 1;
  endfunction

endpackage

// File: rtl/pcm_fifo_store.sv
module pcm_fifo_store #(
  parameter int DEPTH = 16,
  parameter int SW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [SW-1:0] wdata,
  input  logic          pop,
  input  logic [AW-1:0] blk,
  output logic [SW-1:0] rdata,
  output logic          ev_over,
  output logic          ev_under,
  output logic          ev_req
);

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full, empty, push_ok, pop_ok;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign ev_over  = push && full;
  assign ev_under = pop && empty;
  assign ev_req   = pop_ok && !push_ok &&
                    pcm_fifo_pkg::req_hit(32'(cnt), DEPTH, 32'(blk));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      rdata  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(pcm_fifo_pkg::ptr_next(32'(wr_ptr), DEPTH));
      if (pop_ok) begin
        rd_ptr <= AW'(pcm_fifo_pkg::ptr_next(32'(rd_ptr), DEPTH));
        rdata  <= mem[rd_ptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R3: a rejected write leaves the buffer full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);

  // R4: an empty pop repeats the previous sample
  p_underrun_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(rdata));

  // R2: fill level never leaves its range
  p_fill_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/pcm_burst_watch.sv
module pcm_burst_watch #(
  parameter int BW    = 4,
  localparam int CW   = BW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_wr,
  input  logic [BW-1:0] blk,
  input  logic          restart,
  output logic          ev_err
);

  logic [CW-1:0] cnt;
  logic          at_limit;

  assign at_limit = pcm_fifo_pkg::burst_full(32'(cnt), 32'(blk));
  assign ev_err   = dma_wr && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (restart)              cnt <= '0;
    else if (dma_wr && !at_limit)  cnt <= cnt + CW'(1);
  end

  // R6: a data request starts a fresh burst
  p_burst_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R6: the count stays within one block of the largest size
  p_burst_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(1 << BW));

endmodule

// File: rtl/pcm_irq_regs.sv
module pcm_irq_regs #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] events,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic         clr_we,
  input  logic [N-1:0] clr_wdata,
  output logic [N-1:0] status,
  output logic [N-1:0] enable,
  output logic         irq
);

  logic [N-1:0] clr_mask;

  assign clr_mask = clr_we ? clr_wdata : '0;
  assign irq      = |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clr_mask) | events;
      if (en_we) enable <= en_wdata;
    end
  end

  // R1: with nothing enabled the line stays low
  p_quiet_unless_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

  for (genvar i = 0; i < N; i++) begin : g_bit
    // R10: an event in the clearing cycle keeps its bit
    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      events[i] |=> status[i]);
    // R9: a one in the clear write drops the bit
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_wdata[i] && !events[i]) |=> !status[i]);
    // R7: an uncleared bit stays set
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(clr_we && clr_wdata[i])) |=> status[i]);
  end

endmodule

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo #(
  parameter int DEPTH = 16,
  parameter int SW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int NI   = pcm_fifo_pkg::NIRQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_from_dma,
  input  logic [SW-1:0] wr_data,
  input  logic          rd_pop,
  output logic [SW-1:0] rd_sample,
  input  logic [AW-1:0] blk_size,
  input  logic          irq_en_we,
  input  logic [NI-1:0] irq_en_wdata,
  input  logic          irq_clr_we,
  input  logic [NI-1:0] irq_clr_wdata,
  output logic [NI-1:0] irq_enable,
  output logic [NI-1:0] irq_status,
  output logic          irq_line
);

  logic          ev_over, ev_under, ev_req, ev_blkerr;
  logic          dma_wr;
  logic [NI-1:0] events;

  assign dma_wr = wr_valid && wr_from_dma;

  pcm_fifo_store #(.DEPTH(DEPTH), .SW(SW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (wr_valid),
    .wdata   (wr_data),
    .pop     (rd_pop),
    .blk     (blk_size),
    .rdata   (rd_sample),
    .ev_over (ev_over),
    .ev_under(ev_under),
    .ev_req  (ev_req)
  );

  pcm_burst_watch #(.BW(AW)) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .dma_wr (dma_wr),
    .blk    (blk_size),
    .restart(ev_req),
    .ev_err (ev_blkerr)
  );

  always_comb begin
    events = '0;
    events[pcm_fifo_pkg::IRQ_BLKERR] = ev_blkerr;
    events[pcm_fifo_pkg::IRQ_UNDER]  = ev_under;
    events[pcm_fifo_pkg::IRQ_OVER]   = ev_over;
    events[pcm_fifo_pkg::IRQ_REQ]    = ev_req;
  end

  pcm_irq_regs #(.N(NI)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .events   (events),
    .en_we    (irq_en_we),
    .en_wdata (irq_en_wdata),
    .clr_we   (irq_clr_we),
    .clr_wdata(irq_clr_wdata),
    .status   (irq_status),
    .enable   (irq_enable),
    .irq      (irq_line)
  );

  // R11: CPU-only writes never raise the burst error
  p_cpu_not_counted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_from_dma) |-> !ev_blkerr);

  // R5: a request only comes from a pop
  p_req_on_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req |-> rd_pop);

endmodule

// File: tb/pcm_sample_fifo_bench.sv
`timescale 1ns/1ps
module pcm_sample_fifo_bench;

  localparam int DEPTH = 16;
  localparam int SW    = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int BLK   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, wr_from_dma = 1'b0, rd_pop = 1'b0;
  logic [SW-1:0] wr_data = '0;
  logic [SW-1:0] rd_sample;
  logic [AW-1:0] blk_size = AW'(BLK);
  logic          irq_en_we = 1'b0, irq_clr_we = 1'b0;
  logic [3:0]    irq_en_wdata = '0, irq_clr_wdata = '0;
  logic [3:0]    irq_enable, irq_status;
  logic          irq_line;

  always #2.5 clk = ~clk;

  pcm_sample_fifo #(.DEPTH(DEPTH), .SW(SW)) u_pcm_sample_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_from_dma(wr_from_dma),
    .wr_data(wr_data), .rd_pop(rd_pop), .rd_sample(rd_sample), .blk_size(blk_size),
    .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata), .irq_clr_we(irq_clr_we),
    .irq_clr_wdata(irq_clr_wdata), .irq_enable(irq_enable), .irq_status(irq_status),
    .irq_line(irq_line)
  );

  int n_checks = 0, n_fail = 0;
  logic [SW-1:0] sq[$];
  logic [SW-1:0] last_out = '0;
  logic [3:0]    mst = '0, men = '0;
  int            bcnt = 0;
  logic          mon_pend = 1'b0;
  logic [SW-1:0] mon_exp = '0;
  string         mon_tag = "";

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare the delivered sample against the scoreboard, off the edge
  always @(negedge clk) begin
    if (mon_pend) begin
      check(rd_sample == mon_exp, mon_tag, "rd_sample", rd_sample, mon_exp);
      mon_pend = 1'b0;
    end
  end

  // driver: one cycle of stimulus, updating the reference model
  task automatic step(input bit psh, input logic [SW-1:0] d, input bit dma,
                      input bit pp, input logic [3:0] clr, input string tag);
    int sz;
    bit pacc, pok;
    logic [3:0] ev;
    logic [SW-1:0] outv;
    sz   = sq.size();
    pacc = psh && (sz < DEPTH);
    pok  = pp && (sz > 0);
    ev   = '0;
    if (psh && sz == DEPTH) ev[2] = 1'b1;
    if (pp && sz == 0) ev[1] = 1'b1;
    if (pok) begin
      outv = sq.pop_front();
      last_out = outv;
      if (!pacc && (DEPTH - (sz - 1)) == BLK + 1) ev[3] = 1'b1;
    end else begin
      outv = last_out;
    end
    if (pacc) sq.push_back(d);
    if (psh && dma) begin
      if (bcnt == BLK + 1) ev[0] = 1'b1;
      else bcnt++;
    end
    if (ev[3]) bcnt = 0;
    wr_valid = psh; wr_data = d; wr_from_dma = dma; rd_pop = pp;
    irq_clr_we = 1'b1; irq_clr_wdata = clr;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_from_dma = 1'b0; rd_pop = 1'b0;
    irq_clr_we = 1'b0; irq_clr_wdata = '0;
    mst = (mst & ~clr) | ev;
    if (pp) begin
      mon_exp = outv;
      mon_tag = pok ? "R2" : "R4";
      mon_pend = 1'b1;
    end
    check(irq_status == mst, tag, "irq_status", irq_status, mst);
    check(irq_line == |(mst & men), "R8", "irq_line", irq_line, |(mst & men));
  endtask

  task automatic set_en(input logic [3:0] m);
    irq_en_we = 1'b1; irq_en_wdata = m;
    @(posedge clk); #1;
    irq_en_we = 1'b0;
    men = m;
    check(irq_enable == m, "R8", "irq_enable", irq_enable, m);
    check(irq_line == |(mst & men), "R8", "irq_line", irq_line, |(mst & men));
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check(irq_status == 0, "R1", "irq_status", irq_status, 0);
    check(irq_enable == 0, "R1", "irq_enable", irq_enable, 0);
    check(irq_line == 0, "R1", "irq_line", irq_line, 0);
    check(rd_sample == 0, "R1", "rd_sample", rd_sample, 0);

    // R2 ordering with CPU writes
    for (int i = 0; i < 5; i++) step(1, 16'h8000 + 16'(i * 7), 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, "R2");
    // R4 underrun repeats the last sample, R7 with nothing enabled
    step(0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 0, 0, "R7");

    // R8 enable gating, R9 zero write ignored then clear
    set_en(4'b0010);
    step(0, 0, 0, 0, 4'b0000, "R9");
    step(0, 0, 0, 0, 4'b0010, "R9");
    set_en(4'b0000);

    // R3 overflow discards, R5 request on the fourth pop
    for (int i = 0; i < DEPTH; i++) step(1, 16'h1000 + 16'(i), 0, 0, 0, "R3");
    step(1, 16'hDEAD, 0, 0, 0, "R3");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, "R5");
    step(0, 0, 0, 0, 4'hF, "R9");

    // R11 CPU writes not counted, R6 fifth DMA write errors
    for (int i = 0; i < 6; i++) step(1, 16'h2000 + 16'(i), 0, 0, 0, "R11");
    for (int i = 0; i < 4; i++) step(1, 16'h3000 + 16'(i), 1, 0, 0, "R11");
    step(1, 16'h3004, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 4'hF, "R9");
    // request restarts the burst count
    for (int i = 0; i < 2; i++) step(1, 16'h4000 + 16'(i), 0, 0, 0, "R6");
    step(0, 0, 0, 1, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 16'h5000 + 16'(i), 1, 0, 0, "R6");
    step(1, 16'h5004, 1, 0, 0, "R6");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 4'hF, "R9");

    // R10 event beats a same-cycle clear
    step(0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 1, 4'b0010, "R10");
    step(0, 0, 0, 0, 4'b0010, "R9");

    // R7 latch without enable, R8 line follows a later enable
    set_en(4'b1000);
    step(0, 0, 0, 1, 0, "R7");
    set_en(4'b0010);
    set_en(4'b1111);

    repeat (3) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule